// File: doc/BRIEF.md
# Asynchronous DRAM Controller with CAS-before-RAS Refresh

This block connects a host request port to an asynchronous DRAM whose address pins carry the row and the column at different times. For each host read or write it drives the row half of the host address, pulls RAS low to latch it, then switches the bus to the column half and pulls CAS low. On a write it drives the host data and lowers write-enable before CAS falls. On a read it captures the device data in the last CAS cycle and returns it together with the acknowledge.

A free-running interval timer produces one refresh request every 15.625 µs, with the cycle count taken from the clock-frequency parameter. Refresh cycles lower CAS one cycle before RAS, so the device's own row counter selects the row and the controller only chooses when to refresh. An access that has started always runs to completion. Requests that come due in the meantime are held in a counter, so none is dropped. When a refresh is owed and a host request waits in the same idle cycle, the refresh goes first.

The host raises `req` and holds `we`, `addr` and `wdata` until `ack` pulses. It then lowers `req`, or keeps it high and presents the next operation.

Top module: `dramc_top`

## Requirements
- R1: While reset is applied and afterwards until the first operation, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high and `ack` is low.
- R2: An access drives the row half (upper ROW_W bits of `addr`) on `dram_addr` for one cycle with RAS high, then lowers RAS. T_RCD cycles later it drives the column half (lower COL_W bits) for one cycle, then lowers CAS exactly T_RCD+1 cycles after RAS fell. CAS stays low for T_CAS cycles, and the bus stays stable while CAS is low.
- R3: On a write (`we`=1), `dram_we_n` goes low in the column cycle, one cycle before CAS falls, and `dram_d` equals `wdata` when CAS falls. On a read `dram_we_n` stays high.
- R4: `ack` is a single-cycle pulse in the cycle after the last CAS-low cycle. On a read, `rdata` in that cycle equals `dram_q` as sampled in the last CAS-low cycle.
- R5: RAS never falls for an access unless `req` is high.
- R6: A refresh lowers CAS with RAS high and `dram_we_n` high, lowers RAS one cycle later, keeps both low for T_RCD+T_CAS cycles, and raises both together.
- R7: The refresh interval is CLK_MHZ*15625/1000 cycles. Counting from the release of reset, the k-th interval ends at cycle k times that value, and its refresh starts within 12 cycles of the interval's end.
- R8: A refresh never starts while RAS is low for an access. A refresh that comes due during an access starts only after that access and its precharge.
- R9: In an idle cycle where a refresh is owed and `req` is high, the refresh is started first.
- R10: Owed refreshes are counted rather than dropped, so the number of refresh cycles equals the number of elapsed intervals.
- R11: RAS stays high for at least T_RP cycles between any two RAS-low periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | Host word address, row in the upper bits |
| wdata | input | DATA_W | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data, valid with ack |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | DATA_W | Data to the device |
| dram_q | input | DATA_W | Data from the device |

## Verification
The bench builds the controller with 3-bit row and column fields and a 2 MHz clock parameter. This gives a 64-word array and a 31-cycle refresh interval. Each of the 64 words is written and read back twice: once with idle gaps between operations and once back to back. Refresh requests therefore land in every phase of an access, and the arbitration, the hold-off and the owed-refresh count are all exercised. At the middle of every interval the refresh total is compared with the number of elapsed intervals.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_RCAS,
        ST_RRAS,
        ST_PRE
    } dramc_state_e;

    localparam int unsigned REF_PERIOD_NS_DEF = 15625;

endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
    parameter int unsigned REF_CYC = 781
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == TW'(REF_CYC - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dramc_ref_pending.sv
module dramc_ref_pending #(
    parameter int unsigned PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              take,
    output logic [PEND_W-1:0] count
);
    logic [PEND_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !take) begin
            if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
        end else if (take && !inc) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/dramc_addr_split.sv
module dramc_addr_split #(
    parameter int unsigned ROW_W = 8,
    parameter int unsigned COL_W = 8,
    parameter int unsigned MUX_W = 8
) (
    input  logic [ROW_W+COL_W-1:0] host_addr,
    output logic [MUX_W-1:0]       row_bus,
    output logic [MUX_W-1:0]       col_bus
);
    localparam int unsigned AW = ROW_W + COL_W;

    generate
        if (ROW_W == MUX_W) begin : g_row_full
            assign row_bus = host_addr[AW-1 -: ROW_W];
        end else begin : g_row_pad
            assign row_bus = {{(MUX_W-ROW_W){1'b0}}, host_addr[AW-1 -: ROW_W]};
        end
        if (COL_W == MUX_W) begin : g_col_full
            assign col_bus = host_addr[COL_W-1:0];
        end else begin : g_col_pad
            assign col_bus = {{(MUX_W-COL_W){1'b0}}, host_addr[COL_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/dramc_top.sv
module dramc_top
    import dramc_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 50,
    parameter int unsigned REF_PERIOD_NS = REF_PERIOD_NS_DEF,
    parameter int unsigned ROW_W         = 8,
    parameter int unsigned COL_W         = 8,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned T_RCD         = 2,
    parameter int unsigned T_CAS         = 2,
    parameter int unsigned T_RP          = 3,
    parameter int unsigned PEND_W        = 4,
    localparam int unsigned ADDR_W       = ROW_W + COL_W,
    localparam int unsigned MUX_W        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_d,
    input  logic [DATA_W-1:0] dram_q
);
    localparam int unsigned REF_CYC  = (CLK_MHZ * REF_PERIOD_NS) / 1000;
    localparam int unsigned T_REFLOW = T_RCD + T_CAS;
    localparam int unsigned T_MAX0   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int unsigned T_MAX1   = (T_MAX0 > T_RP) ? T_MAX0 : T_RP;
    localparam int unsigned T_MAX    = (T_MAX1 > T_REFLOW) ? T_MAX1 : T_REFLOW;
    localparam int unsigned CNT_W    = $clog2(T_MAX + 1);

    typedef struct packed {
        dramc_state_e       state;
        logic [CNT_W-1:0]   cnt;
        logic [MUX_W-1:0]   addr;
        logic               ras_n;
        logic               cas_n;
        logic               we_n;
        logic               ack;
        logic [DATA_W-1:0]  rdata;
        logic [DATA_W-1:0]  wd;
    } regs_t;

    regs_t r_d, r_q;

    logic              ref_tick;
    logic              ref_take;
    logic              pend_any;
    logic [PEND_W-1:0] pend_cnt;
    logic [MUX_W-1:0]  row_bus;
    logic [MUX_W-1:0]  col_bus;

    dramc_ref_timer #(.REF_CYC(REF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick)
    );

    dramc_ref_pending #(.PEND_W(PEND_W)) u_pending (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ref_tick),
        .take  (ref_take),
        .count (pend_cnt)
    );

    dramc_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)) u_split (
        .host_addr (addr),
        .row_bus   (row_bus),
        .col_bus   (col_bus)
    );

    assign pend_any = (pend_cnt != '0);
    assign ref_take = (r_q.state == ST_IDLE) && pend_any;

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (pend_any) begin
                    r_d.state = ST_RCAS;
                    r_d.cas_n = 1'b0;
                end else if (req) begin
                    r_d.state = ST_ROW;
                    r_d.addr  = row_bus;
                    r_d.wd    = wdata;
                end
            end
            ST_ROW: begin
                r_d.state = ST_RAS;
                r_d.ras_n = 1'b0;
                r_d.cnt   = CNT_W'(T_RCD - 1);
            end
            ST_RAS: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_COL;
                    r_d.addr  = col_bus;
                    r_d.we_n  = ~we;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                r_d.state = ST_CAS;
                r_d.cas_n = 1'b0;
                r_d.cnt   = CNT_W'(T_CAS - 1);
            end
            ST_CAS: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_PRE;
                    r_d.ras_n = 1'b1;
                    r_d.cas_n = 1'b1;
                    r_d.we_n  = 1'b1;
                    r_d.ack   = 1'b1;
                    if (r_q.we_n) r_d.rdata = dram_q;
                    r_d.cnt   = CNT_W'(T_RP - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_RCAS: begin
                r_d.state = ST_RRAS;
                r_d.ras_n = 1'b0;
                r_d.cnt   = CNT_W'(T_REFLOW - 1);
            end
            ST_RRAS: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_PRE;
                    r_d.ras_n = 1'b1;
                    r_d.cas_n = 1'b1;
                    r_d.cnt   = CNT_W'(T_RP - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (r_q.cnt == '0) r_d.state = ST_IDLE;
                else               r_d.cnt   = r_q.cnt - 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.addr  <= '0;
            r_q.ras_n <= 1'b1;
            r_q.cas_n <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.ack   <= 1'b0;
            r_q.rdata <= '0;
            r_q.wd    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack        = r_q.ack;
    assign rdata      = r_q.rdata;
    assign dram_addr  = r_q.addr;
    assign dram_ras_n = r_q.ras_n;
    assign dram_cas_n = r_q.cas_n;
    assign dram_we_n  = r_q.we_n;
    assign dram_d     = r_q.wd;
endmodule

// File: rtl/dramc_checker.sv
module dramc_checker #(
    parameter int unsigned T_RP   = 3,
    parameter int unsigned MUX_W  = 8,
    parameter int unsigned PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              ack,
    input logic [MUX_W-1:0]  dram_addr,
    input logic [PEND_W-1:0] pend_cnt
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      hi_cnt <= 8'(T_RP);
        else if (!ras_n) hi_cnt <= '0;
        else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
    end

    p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_ack_after_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(!cas_n));

    p_we_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $fell(cas_n)) |-> $stable(we_n));

    p_cbr_we_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && $fell(cas_n)) |-> we_n);

    p_cbr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && !cas_n) |=> !ras_n);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));

    p_precharge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= 8'(T_RP)));

    p_pend_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == '1) |=> (pend_cnt != '0));
endmodule

bind dramc_top dramc_checker #(
    .T_RP   (T_RP),
    .MUX_W  (MUX_W),
    .PEND_W (PEND_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .ack       (ack),
    .dram_addr (dram_addr),
    .pend_cnt  (pend_cnt)
);

// File: tb/dramc_top_bench.sv
module dramc_top_bench;
    localparam int RW    = 3;
    localparam int CW    = 3;
    localparam int DW    = 8;
    localparam int AW    = RW + CW;
    localparam int NW    = 1 << AW;
    localparam int TRCD  = 2;
    localparam int TCAS  = 2;
    localparam int TRP   = 3;
    localparam int MHZ   = 2;
    localparam int REF   = (MHZ * 15625) / 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          ack;
    logic [DW-1:0] rdata;
    logic [RW-1:0] dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_we_n;
    logic [DW-1:0] dram_d;
    logic [DW-1:0] dram_q;

    always #4 clk = ~clk;

    dramc_top #(
        .CLK_MHZ(MHZ), .ROW_W(RW), .COL_W(CW), .DATA_W(DW),
        .T_RCD(TRCD), .T_CAS(TCAS), .T_RP(TRP), .PEND_W(4)
    ) u_dramc_top (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_d(dram_d), .dram_q(dram_q)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit timeout = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // device model
    logic [DW-1:0] mem [NW];
    logic [RW-1:0] row_lat = '0;
    assign dram_q = dram_cas_n ? '0 : mem[{row_lat, dram_addr}];

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // host-side expectations
    logic          cur_we = 1'b0;
    logic [AW-1:0] cur_a = '0;
    logic [DW-1:0] cur_d = '0;

    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, prev_ack = 1'b0;
    logic [RW-1:0] prev_addr = '0;
    int t_rasf = 0, t_casf = 0, t_rasr = -100, refs = 0;
    bit in_acc = 0, in_ref = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ack && ack) chk(0, "R4 ack longer than one cycle", 1, 0);
            if (prev_ras && !dram_ras_n) begin
                chk(cyc - t_rasr >= TRP, "R11 precharge", cyc - t_rasr, TRP);
                t_rasf = cyc;
                if (dram_cas_n) begin
                    in_acc = 1;
                    row_lat = dram_addr;
                    chk(req == 1'b1, "R5 RAS without request", req, 1);
                    chk(dram_addr == prev_addr, "R2 row setup", prev_addr, dram_addr);
                    chk(dram_addr == cur_a[AW-1 -: RW], "R2 row value", dram_addr, cur_a[AW-1 -: RW]);
                end else begin
                    in_ref = 1;
                    chk(cyc - t_casf == 1, "R6 CAS leads RAS", cyc - t_casf, 1);
                end
            end
            if (prev_cas && !dram_cas_n) begin
                t_casf = cyc;
                if (dram_ras_n) begin
                    refs++;
                    chk(dram_we_n == 1'b1, "R6 WE high in refresh", dram_we_n, 1);
                    chk((cyc % REF) >= 1 && (cyc % REF) <= 12, "R7 R8 R9 refresh latency", cyc % REF, 1);
                end else begin
                    chk(in_acc && !in_ref, "R8 CAS during non-access", in_ref, 0);
                    chk(cyc - t_rasf == TRCD + 1, "R2 RAS to CAS", cyc - t_rasf, TRCD + 1);
                    chk(dram_addr == cur_a[CW-1:0], "R2 column value", dram_addr, cur_a[CW-1:0]);
                    chk(dram_we_n == !cur_we, "R3 WE level", dram_we_n, !cur_we);
                    chk(prev_we == dram_we_n, "R3 WE setup before CAS", prev_we, dram_we_n);
                    if (cur_we) begin
                        chk(dram_d == cur_d, "R3 write data", dram_d, cur_d);
                        mem[{row_lat, dram_addr}] = dram_d;
                    end
                end
            end
            if (!prev_cas && dram_cas_n && in_acc)
                chk(cyc - t_casf == TCAS, "R2 CAS width", cyc - t_casf, TCAS);
            if (!prev_ras && dram_ras_n) begin
                if (in_ref) begin
                    chk(cyc - t_rasf == TRCD + TCAS, "R6 refresh RAS width", cyc - t_rasf, TRCD + TCAS);
                    chk(dram_cas_n == 1'b1, "R6 strobes rise together", dram_cas_n, 1);
                end
                t_rasr = cyc;
                in_acc = 0;
                in_ref = 0;
            end
            if (cyc % REF == 15)
                chk(refs == cyc / REF, "R7 R10 refresh count", refs, cyc / REF);
        end
        prev_ras  = dram_ras_n;
        prev_cas  = dram_cas_n;
        prev_we   = dram_we_n;
        prev_ack  = ack;
        prev_addr = dram_addr;
    end

    function automatic logic [DW-1:0] pat(input int a, input int pass);
        return (pass == 0) ? DW'((a * 37 + 5) & 255) : DW'(((a * 11) ^ 8'h5A) & 255);
    endfunction

    task automatic op(input logic w, input int a, input logic [DW-1:0] d, input bit hold);
        int guard = 0;
        req = 1'b1; we = w; addr = AW'(a); wdata = d;
        cur_we = w; cur_a = AW'(a); cur_d = d;
        do begin
            @(negedge clk);
            guard++;
        end while (!ack && guard < 200 && !timeout);
        chk(ack == 1'b1, "R4 ack arrives", ack, 1);
        if (!w) chk(rdata == d, "R4 read data", rdata, d);
        if (!hold) req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high in reset",
            {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        chk(ack == 1'b0, "R1 ack low in reset", ack, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && dram_we_n && !ack, "R1 idle after reset",
            {dram_ras_n, dram_cas_n, dram_we_n, ack}, 14);
        repeat (40) @(negedge clk);
        for (int a = 0; a < NW; a++) begin
            op(1'b1, a, pat(a, 0), 1'b0);
            @(negedge clk);
        end
        for (int a = 0; a < NW; a++) begin
            op(1'b0, a, pat(a, 0), 1'b0);
            @(negedge clk);
        end
        for (int a = 0; a < NW; a++) op(1'b1, NW - 1 - a, pat(NW - 1 - a, 1), 1'b1);
        for (int a = 0; a < NW; a++) op(1'b0, a, pat(a, 1), a != NW - 1);
        req = 1'b0;
        repeat (70) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        timeout = 1;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule